// File: doc/BRIEF.md
# Vector-to-Port Element Distributor

This block connects one wide vector word of eight elements to four narrow queues that feed an accelerator. A small programmable map gives every element position three things: a destination queue, an enable, and a slot number. The slot number fixes where that element lands among the other elements sent to the same queue. With this map, strided, interleaved or reversed element patterns can be spread over the queues in any arrangement. Disabled positions are dropped.

The same map also works in the return direction. The accelerator pushes result tokens into four result queues. Once every enabled map entry has a token waiting at its queue, the block builds one vector word from them. It places the tokens in the same per-queue order that the scatter direction uses, and offers the word for storing.

The gather side runs a two-state machine:
- `G_COLLECT` waits until every enabled entry is covered by waiting tokens. The transition *capture* then moves it to `G_HOLD`, pops the tokens it used and registers the word.
- `G_HOLD` presents the word. The transition *release* returns it to `G_COLLECT` when the consumer takes the word.

The map may only be rewritten while all eight queues are empty.

Top module: `vec_port_dist`

## Requirements
- R1: After reset, every map entry is disabled, `map_err` is 0, no `ip_valid` bit is set, `gv_valid` is 0 and `sv_ready` is 1.
- R2: A map write carries `map_wdata` = {enable (bit 4), slot (bits 3:2), queue (bits 1:0)} for element `map_idx`. On an accepted vector word, each enabled element (bits 32e+31:32e of `sv_data`) enters the queue its entry names. Disabled elements enter no queue.
- R3: Elements sent to the same queue by one word are enqueued in ascending slot order. Ties in slot are broken by lower element index first.
- R4: `sv_ready` is 1 exactly when, for every queue, the number of enabled entries naming it does not exceed its free space (8 minus its occupancy).
- R5: Each queue holds 8 tokens of 32 bits. `ip_valid[p]` is 1 exactly when input queue p is non-empty, and `ip_data` slice p shows its head. The head is removed on `ip_valid & ip_ready`. It holds steady otherwise. `op_ready[p]` is 0 when result queue p holds 8 tokens.
- R6: `gv_valid` rises one cycle after every queue holds at least as many tokens as enabled entries name it. In that word, element e is the token at the position that R3 gives e within its queue. Disabled elements read as zero. `gv_mask` bit e equals entry e's enable.
- R7: While `gv_valid` is 1 and `gv_ready` is 0, `gv_data` and `gv_mask` stay unchanged. After a cycle with `gv_valid & gv_ready`, `gv_valid` is 0 for the next cycle.
- R8: A map write while any of the eight queues is non-empty leaves the map unchanged and sets `map_err`, which stays 1 until reset.
- R9: With no entry enabled, vector words are accepted and dropped, and no gathered word is ever offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_we | input | 1 | Map entry write strobe |
| map_idx | input | 3 | Element position being written |
| map_wdata | input | 5 | {enable, slot[1:0], queue[1:0]} |
| map_err | output | 1 | Sticky flag: a map write was refused |
| sv_valid | input | 1 | Vector word offered for scatter |
| sv_ready | output | 1 | Vector word can be accepted |
| sv_data | input | 256 | Eight 32-bit elements, element e at bits 32e+31:32e |
| ip_valid | output | 4 | Per-queue head valid toward accelerator |
| ip_ready | input | 4 | Per-queue pop from accelerator |
| ip_data | output | 128 | Per-queue head token, queue p at bits 32p+31:32p |
| op_valid | input | 4 | Per-queue result token offered |
| op_ready | output | 4 | Per-queue result queue has room |
| op_data | input | 128 | Per-queue result token |
| gv_valid | output | 1 | Gathered vector word valid |
| gv_ready | input | 1 | Gathered vector word taken |
| gv_data | output | 256 | Gathered vector word |
| gv_mask | output | 8 | Which elements of the gathered word are enabled |

## Verification
The sweep covers several map shapes:
- Slot ties decide order, which catches a design that sorts by slot alone and reorders tied elements.
- Slots are reversed against element index, which catches a design that enqueues by index and ignores slots.
- All elements go to one queue, which catches a design that puts parallel writes at wrong positions when the pointer wraps.
- Random maps are also generated.

Backpressure is checked at the exact boundary. Half a queue's free space must still accept a four-element word, and no free space must refuse it. An off-by-one room test would either overflow the queue or stall one word early.

The gather side is checked before, at and after the cycle in which the last needed token arrives. A design that fired early would emit stale data, and a design that compared against the wrong count would hang.

A refused map write is probed by scattering afterwards. A design that applied the write anyway would send an extra element to the queue that the refused write named.

// File: rtl/vdist_pkg.sv
package vdist_pkg;
    localparam int NELEM  = 8;
    localparam int NPORT  = 4;
    localparam int NSLOT  = 4;
    localparam int ELEM_W = $clog2(NELEM);
    localparam int PORT_W = $clog2(NPORT);
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int ENT_W  = 1 + SLOT_W + PORT_W;
    localparam int RANK_W = $clog2(NELEM);
    localparam int NEED_W = $clog2(NELEM + 1);

    typedef struct packed {
        logic              en;
        logic [SLOT_W-1:0] slot;
        logic [PORT_W-1:0] port;
    } map_ent_t;

    typedef enum logic [0:0] {
        G_COLLECT = 1'b0,
        G_HOLD    = 1'b1
    } gat_state_e;
endpackage

// File: rtl/vdist_fifo.sv
module vdist_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int LANES = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [$clog2(LANES+1)-1:0]       push_n,
    input  logic [LANES-1:0][DW-1:0]         push_data,
    input  logic [$clog2(LANES+1)-1:0]       pop_n,
    output logic [LANES-1:0][DW-1:0]         peek,
    output logic [$clog2(DEPTH+1)-1:0]       count,
    output logic                             full,
    output logic                             empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;

    // pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            wptr_q <= wptr_q + PTR_W'(push_n);
            rptr_q <= rptr_q + PTR_W'(pop_n);
            cnt_q  <= cnt_q + CNT_W'(push_n) - CNT_W'(pop_n);
        end
    end

    // parallel write of up to LANES tokens, lane k lands k places after the tail
    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(push_n)) begin
                mem[wptr_q + PTR_W'(k)] <= push_data[k];
            end
        end
    end

    // window of the oldest LANES tokens
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            peek[k] = mem[rptr_q + PTR_W'(k)];
        end
    end

    assign count = cnt_q;
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);
endmodule

// File: rtl/vdist_map.sv
module vdist_map
    import vdist_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ELEM_W-1:0]             idx,
    input  map_ent_t                      wdata,
    input  logic                          fifos_idle,
    output map_ent_t [NELEM-1:0]          ent,
    output logic [NELEM-1:0][RANK_W-1:0]  rank,
    output logic [NPORT-1:0][NEED_W-1:0]  need,
    output logic                          err
);
    map_ent_t [NELEM-1:0] ent_q;
    logic                 err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
            err_q <= 1'b0;
        end else if (we) begin
            if (fifos_idle) begin
                ent_q[idx] <= wdata;
            end else begin
                err_q <= 1'b1;
            end
        end
    end

    // position of each element among the elements sharing its port:
    // lower slot first, equal slots by lower element index
    always_comb begin
        for (int e = 0; e < NELEM; e++) begin
            rank[e] = '0;
            for (int j = 0; j < NELEM; j++) begin
                if (j != e && ent_q[j].en && ent_q[j].port == ent_q[e].port &&
                    (ent_q[j].slot < ent_q[e].slot ||
                     (ent_q[j].slot == ent_q[e].slot && j < e))) begin
                    rank[e] = rank[e] + RANK_W'(1);
                end
            end
        end
    end

    // enabled elements per port
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            need[p] = '0;
            for (int e = 0; e < NELEM; e++) begin
                if (ent_q[e].en && int'(ent_q[e].port) == p) begin
                    need[p] = need[p] + NEED_W'(1);
                end
            end
        end
    end

    assign ent = ent_q;
    assign err = err_q;
endmodule

// File: rtl/vdist_scatter.sv
module vdist_scatter
    import vdist_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  map_ent_t [NELEM-1:0]                       ent,
    input  logic [NELEM-1:0][RANK_W-1:0]               rank,
    input  logic [NPORT-1:0][NEED_W-1:0]               need,
    input  logic [NPORT-1:0][$clog2(DEPTH+1)-1:0]      icount,
    input  logic                                       sv_valid,
    input  logic [NELEM-1:0][DW-1:0]                   sv_elems,
    output logic                                       sv_ready,
    output logic [NPORT-1:0][NEED_W-1:0]               push_n,
    output logic [NPORT-1:0][NELEM-1:0][DW-1:0]        push_data
);
    logic accept;

    // room test: every port must take its whole share of the word
    always_comb begin
        sv_ready = 1'b1;
        for (int p = 0; p < NPORT; p++) begin
            if (int'(need[p]) > DEPTH - int'(icount[p])) begin
                sv_ready = 1'b0;
            end
        end
    end

    assign accept = sv_valid && sv_ready;

    // route element e to lane rank[e] of its port
    always_comb begin
        push_data = '0;
        for (int e = 0; e < NELEM; e++) begin
            if (ent[e].en) begin
                push_data[ent[e].port][rank[e]] = sv_elems[e];
            end
        end
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            push_n[p] = accept ? need[p] : '0;
        end
    end
endmodule

// File: rtl/vdist_gather.sv
module vdist_gather
    import vdist_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  map_ent_t [NELEM-1:0]                       ent,
    input  logic [NELEM-1:0][RANK_W-1:0]               rank,
    input  logic [NPORT-1:0][NEED_W-1:0]               need,
    input  logic [NPORT-1:0][$clog2(DEPTH+1)-1:0]      ocount,
    input  logic [NPORT-1:0][NELEM-1:0][DW-1:0]        opeek,
    output logic [NPORT-1:0][NEED_W-1:0]               pop_n,
    output logic                                       gv_valid,
    input  logic                                       gv_ready,
    output logic [NELEM-1:0][DW-1:0]                   gv_elems,
    output logic [NELEM-1:0]                           gv_mask
);
    gat_state_e             state_q, state_d;
    logic                   covered;
    logic                   any_en;
    logic                   capture;
    logic [NELEM-1:0][DW-1:0] data_q;
    logic [NELEM-1:0]       mask_q;

    always_comb begin
        covered = 1'b1;
        any_en  = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            if (int'(need[p]) > int'(ocount[p])) begin
                covered = 1'b0;
            end
        end
        for (int e = 0; e < NELEM; e++) begin
            any_en = any_en | ent[e].en;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= G_COLLECT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            G_COLLECT: if (covered && any_en) state_d = G_HOLD;
            G_HOLD:    if (gv_ready)          state_d = G_COLLECT;
            default:   state_d = G_COLLECT;
        endcase
    end

    // outputs
    always_comb begin
        capture  = 1'b0;
        gv_valid = 1'b0;
        unique case (state_q)
            G_COLLECT: capture  = covered && any_en;
            G_HOLD:    gv_valid = 1'b1;
            default:   ;
        endcase
        for (int p = 0; p < NPORT; p++) begin
            pop_n[p] = capture ? need[p] : '0;
        end
    end

    // capture register for the assembled word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            mask_q <= '0;
        end else if (capture) begin
            for (int e = 0; e < NELEM; e++) begin
                mask_q[e] <= ent[e].en;
                data_q[e] <= ent[e].en ? opeek[ent[e].port][rank[e]] : '0;
            end
        end
    end

    assign gv_elems = data_q;
    assign gv_mask  = mask_q;
endmodule

// File: rtl/vec_port_dist.sv
module vec_port_dist
    import vdist_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   map_we,
    input  logic [ELEM_W-1:0]      map_idx,
    input  logic [ENT_W-1:0]       map_wdata,
    output logic                   map_err,
    input  logic                   sv_valid,
    output logic                   sv_ready,
    input  logic [NELEM*DW-1:0]    sv_data,
    output logic [NPORT-1:0]       ip_valid,
    input  logic [NPORT-1:0]       ip_ready,
    output logic [NPORT*DW-1:0]    ip_data,
    input  logic [NPORT-1:0]       op_valid,
    output logic [NPORT-1:0]       op_ready,
    input  logic [NPORT*DW-1:0]    op_data,
    output logic                   gv_valid,
    input  logic                   gv_ready,
    output logic [NELEM*DW-1:0]    gv_data,
    output logic [NELEM-1:0]       gv_mask
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    map_ent_t [NELEM-1:0]                  ent;
    logic [NELEM-1:0][RANK_W-1:0]          rank;
    logic [NPORT-1:0][NEED_W-1:0]          need;
    logic [NPORT-1:0][CNT_W-1:0]           icount, ocount;
    logic [NPORT-1:0]                      iempty, ifull, oempty, ofull;
    logic [NPORT-1:0][NEED_W-1:0]          ipush_n, ipop_n, opush_n, opop_n;
    logic [NPORT-1:0][NELEM-1:0][DW-1:0]   ipush_d, ipeek, opush_d, opeek;
    logic [NELEM-1:0][DW-1:0]              sv_elems, gv_elems;
    logic                                  fifos_idle;

    assign fifos_idle = (&iempty) && (&oempty);
    assign sv_elems   = sv_data;
    assign gv_data    = gv_elems;

    vdist_map u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (map_we),
        .idx        (map_idx),
        .wdata      (map_ent_t'(map_wdata)),
        .fifos_idle (fifos_idle),
        .ent        (ent),
        .rank       (rank),
        .need       (need),
        .err        (map_err)
    );

    vdist_scatter #(.DW(DW), .DEPTH(DEPTH)) u_scatter (
        .ent       (ent),
        .rank      (rank),
        .need      (need),
        .icount    (icount),
        .sv_valid  (sv_valid),
        .sv_elems  (sv_elems),
        .sv_ready  (sv_ready),
        .push_n    (ipush_n),
        .push_data (ipush_d)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        // queue toward the accelerator
        assign ipop_n[p] = NEED_W'(ip_valid[p] && ip_ready[p]);
        assign ip_valid[p] = !iempty[p];
        assign ip_data[p*DW +: DW] = ipeek[p][0];

        vdist_fifo #(.DW(DW), .DEPTH(DEPTH), .LANES(NELEM)) u_ififo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_n    (ipush_n[p]),
            .push_data (ipush_d[p]),
            .pop_n     (ipop_n[p]),
            .peek      (ipeek[p]),
            .count     (icount[p]),
            .full      (ifull[p]),
            .empty     (iempty[p])
        );

        // queue from the accelerator
        assign op_ready[p] = !ofull[p];
        assign opush_n[p]  = NEED_W'(op_valid[p] && op_ready[p]);
        always_comb begin
            opush_d[p]    = '0;
            opush_d[p][0] = op_data[p*DW +: DW];
        end

        vdist_fifo #(.DW(DW), .DEPTH(DEPTH), .LANES(NELEM)) u_ofifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_n    (opush_n[p]),
            .push_data (opush_d[p]),
            .pop_n     (opop_n[p]),
            .peek      (opeek[p]),
            .count     (ocount[p]),
            .full      (ofull[p]),
            .empty     (oempty[p])
        );
    end

    vdist_gather #(.DW(DW), .DEPTH(DEPTH)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .ent      (ent),
        .rank     (rank),
        .need     (need),
        .ocount   (ocount),
        .opeek    (opeek),
        .pop_n    (opop_n),
        .gv_valid (gv_valid),
        .gv_ready (gv_ready),
        .gv_elems (gv_elems),
        .gv_mask  (gv_mask)
    );
endmodule

// File: rtl/vdist_checker.sv
module vdist_checker
    import vdist_pkg::*;
#(
    parameter int DW = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                map_we,
    input logic                map_err,
    input logic [NPORT-1:0]    ip_valid,
    input logic [NPORT-1:0]    ip_ready,
    input logic [NPORT*DW-1:0] ip_data,
    input logic                gv_valid,
    input logic                gv_ready,
    input logic [NELEM*DW-1:0] gv_data,
    input logic [NELEM-1:0]    gv_mask
);
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        map_err |=> map_err) else $error("map_err dropped"); // R8

    AST_ERR_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (map_we && (|ip_valid)) |=> map_err) else $error("busy write not flagged"); // R8

    AST_GV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gv_valid && !gv_ready) |=> (gv_valid && $stable(gv_data) && $stable(gv_mask)))
        else $error("gathered word changed while stalled"); // R7

    AST_GV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (gv_valid && gv_ready) |=> !gv_valid) else $error("no gap after release"); // R7

    AST_GV_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        gv_valid |-> (gv_mask != '0)) else $error("empty map emitted a word"); // R9

    for (genvar p = 0; p < NPORT; p++) begin : g_ip
        AST_IP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (ip_valid[p] && !ip_ready[p]) |=> (ip_valid[p] && $stable(ip_data[p*DW +: DW])))
            else $error("queue head moved without pop"); // R5
    end

    for (genvar e = 0; e < NELEM; e++) begin : g_el
        AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (gv_valid && !gv_mask[e]) |-> (gv_data[e*DW +: DW] == '0))
            else $error("disabled element not zero"); // R6
    end
endmodule

bind vec_port_dist vdist_checker #(.DW(DW)) u_chk (.*);

// File: tb/sim_vec_port_dist.sv
module sim_vec_port_dist;
    localparam int DW = 32;
    localparam int NE = 8;
    localparam int NP = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             map_we = 1'b0;
    logic [2:0]       map_idx = '0;
    logic [4:0]       map_wdata = '0;
    logic             map_err;
    logic             sv_valid = 1'b0;
    logic             sv_ready;
    logic [NE*DW-1:0] sv_data = '0;
    logic [NP-1:0]    ip_valid;
    logic [NP-1:0]    ip_ready = '0;
    logic [NP*DW-1:0] ip_data;
    logic [NP-1:0]    op_valid = '0;
    logic [NP-1:0]    op_ready;
    logic [NP*DW-1:0] op_data = '0;
    logic             gv_valid;
    logic             gv_ready = 1'b0;
    logic [NE*DW-1:0] gv_data;
    logic [NE-1:0]    gv_mask;

    always #4 clk = ~clk;

    vec_port_dist u0 (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic       b_en   [NE];
    logic [1:0] b_port [NE];
    logic [1:0] b_slot [NE];
    int         expn [NP];
    int         expe [NP][NE];
    int         rxn  [NP];
    logic [31:0] rx  [NP][16];
    logic [31:0] seed = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input logic [NE*DW-1:0] act,
                       input logic [NE*DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] wval(input int it, input int e);
        return 32'hA000_0000 | (32'(it) << 8) | 32'(e);
    endfunction

    function automatic logic [31:0] tval(input int it, input int p, input int k);
        return 32'hC000_0000 | (32'(it) << 12) | (32'(p) << 8) | 32'(k);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sv_valid = 1'b0; ip_ready = '0; op_valid = '0; gv_ready = 1'b0; map_we = 1'b0;
        for (int e = 0; e < NE; e++) begin b_en[e] = 1'b0; b_port[e] = '0; b_slot[e] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic map_write(input int i, input logic en, input logic [1:0] port, input logic [1:0] slot);
        @(negedge clk);
        map_we = 1'b1; map_idx = 3'(i); map_wdata = {en, slot, port};
        @(negedge clk);
        map_we = 1'b0;
    endtask

    task automatic load_map();
        for (int e = 0; e < NE; e++) map_write(e, b_en[e], b_port[e], b_slot[e]);
    endtask

    task automatic scatter(input int it);
        int n;
        @(negedge clk);
        for (int e = 0; e < NE; e++) sv_data[e*DW +: DW] = wval(it, e);
        sv_valid = 1'b1;
        n = 0;
        while (!sv_ready && n < 50) begin @(negedge clk); n++; end
        @(negedge clk);
        sv_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        for (int p = 0; p < NP; p++) rxn[p] = 0;
        ip_ready = '1;
        for (int c = 0; c < 12; c++) begin
            for (int p = 0; p < NP; p++) begin
                if (ip_valid[p] && rxn[p] < 16) begin
                    rx[p][rxn[p]] = ip_data[p*DW +: DW];
                    rxn[p]++;
                end
            end
            @(negedge clk);
        end
        ip_ready = '0;
    endtask

    // expected per-port list: slot ascending, then element index ascending
    task automatic build_expect();
        for (int p = 0; p < NP; p++) begin
            expn[p] = 0;
            for (int s = 0; s < 4; s++)
                for (int e = 0; e < NE; e++)
                    if (b_en[e] && int'(b_port[e]) == p && int'(b_slot[e]) == s) begin
                        expe[p][expn[p]] = e;
                        expn[p]++;
                    end
        end
    endtask

    task automatic push_tok(input int p, input logic [31:0] v);
        @(negedge clk);
        op_valid[p] = 1'b1;
        op_data[p*DW +: DW] = v;
        @(negedge clk);
        op_valid[p] = 1'b0;
    endtask

    task automatic run_iter(input int it);
        int total, done_n, pos;
        logic [NE*DW-1:0] expw;
        logic [NE-1:0] expm;
        load_map();
        build_expect();
        // scatter direction
        scatter(it);
        drain();
        for (int p = 0; p < NP; p++) begin
            chk(rxn[p] == expn[p], "R2 element count per queue", NE*DW'(rxn[p]), NE*DW'(expn[p]));
            for (int k = 0; k < expn[p] && k < rxn[p]; k++)
                chk(rx[p][k] == wval(it, expe[p][k]), "R3 enqueue order", NE*DW'(rx[p][k]),
                    NE*DW'(wval(it, expe[p][k])));
        end
        // gather direction
        total = 0;
        for (int p = 0; p < NP; p++) total += expn[p];
        done_n = 0;
        for (int p = 0; p < NP; p++)
            for (int k = 0; k < expn[p]; k++) begin
                push_tok(p, tval(it, p, k));
                done_n++;
                if (done_n < total)
                    chk(gv_valid == 1'b0, "R6 no word before last token", NE*DW'(gv_valid), '0);
            end
        expw = '0; expm = '0;
        for (int e = 0; e < NE; e++) begin
            if (b_en[e]) begin
                pos = 0;
                for (int k = 0; k < expn[b_port[e]]; k++) if (expe[b_port[e]][k] == e) pos = k;
                expw[e*DW +: DW] = tval(it, int'(b_port[e]), pos);
                expm[e] = 1'b1;
            end
        end
        @(negedge clk);
        chk(gv_valid == 1'b1, "R6 word one cycle after coverage", NE*DW'(gv_valid), 1);
        chk(gv_data == expw, "R6 gathered data", gv_data, expw);
        chk(gv_mask == expm, "R6 gathered mask", NE*DW'(gv_mask), NE*DW'(expm));
        @(negedge clk);
        chk(gv_valid && gv_data == expw, "R7 word held while stalled", gv_data, expw);
        gv_ready = 1'b1;
        @(negedge clk);
        gv_ready = 1'b0;
        chk(gv_valid == 1'b0, "R7 gap after release", NE*DW'(gv_valid), '0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(map_err == 1'b0, "R1 map_err clear", NE*DW'(map_err), '0);
        chk(ip_valid == '0, "R1 queues empty", NE*DW'(ip_valid), '0);
        chk(gv_valid == 1'b0, "R1 no gathered word", NE*DW'(gv_valid), '0);
        chk(sv_ready == 1'b1, "R1 ready after reset", NE*DW'(sv_ready), 1);

        // R9 empty map: word dropped, gather idle; R5 result queue full
        scatter(0);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(ip_valid == '0, "R9 disabled word dropped", NE*DW'(ip_valid), '0);
        end
        for (int k = 0; k < 8; k++) push_tok(0, tval(0, 0, k));
        @(negedge clk);
        chk(op_ready[0] == 1'b0, "R5 result queue full at 8", NE*DW'(op_ready[0]), '0);
        chk(op_ready[1] == 1'b1, "R5 other queue has room", NE*DW'(op_ready[1]), 1);
        repeat (3) @(negedge clk);
        chk(gv_valid == 1'b0, "R9 no word with empty map", NE*DW'(gv_valid), '0);

        // R4 backpressure boundary, R8 refused write
        do_reset();
        for (int e = 0; e < 4; e++) begin b_en[e] = 1'b1; b_port[e] = 2'd0; b_slot[e] = 2'(e); end
        load_map();
        scatter(1);
        chk(sv_ready == 1'b1, "R4 room for four more", NE*DW'(sv_ready), 1);
        chk(ip_valid == 4'b0001, "R5 head valid while stalled", NE*DW'(ip_valid), 1);
        scatter(2);
        chk(sv_ready == 1'b0, "R4 no room refuses word", NE*DW'(sv_ready), '0);
        map_write(7, 1'b1, 2'd1, 2'd0);
        chk(map_err == 1'b1, "R8 busy write flagged", NE*DW'(map_err), 1);
        drain();
        chk(rxn[0] == 8, "R5 queue held eight", NE*DW'(rxn[0]), 8);
        for (int k = 0; k < 8; k++)
            chk(rx[0][k] == wval(1 + k / 4, k % 4), "R5 first-in first-out", NE*DW'(rx[0][k]),
                NE*DW'(wval(1 + k / 4, k % 4)));
        chk(sv_ready == 1'b1, "R4 ready after drain", NE*DW'(sv_ready), 1);
        scatter(3);
        drain();
        chk(rxn[1] == 0, "R8 refused entry not applied", NE*DW'(rxn[1]), '0);
        chk(map_err == 1'b1, "R8 flag sticky", NE*DW'(map_err), 1);

        // sweep of maps
        do_reset();
        for (int it = 4; it < 44; it++) begin
            for (int e = 0; e < NE; e++) begin
                if (it == 4) begin
                    // interleave: 0,3 -> q0; 1,4 -> q1; 2,5 -> q2; 6,7 dropped
                    b_en[e] = (e < 6); b_port[e] = 2'(e % 3); b_slot[e] = 2'(e / 3);
                end else if (it == 5) begin
                    b_en[e] = 1'b1; b_port[e] = 2'(e % 4); b_slot[e] = (e < 4) ? 2'd3 : 2'd0;
                end else if (it == 6) begin
                    b_en[e] = 1'b1; b_port[e] = 2'd3; b_slot[e] = 2'd0;
                end else begin
                    seed = seed * 32'd1664525 + 32'd1013904223;
                    b_en[e] = seed[20] | (e == 0);
                    b_port[e] = seed[22:21];
                    b_slot[e] = seed[24:23];
                end
            end
            run_iter(it);
        end
        chk(map_err == 1'b0, "R8 legal writes not flagged", NE*DW'(map_err), '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule